// File: doc/BRIEF.md
# Multi-Port Word Memory with Per-Port Clocking

This block is a word-organised storage array with any number of read ports and write ports. Every port has its own clock input. Each read port is set at elaboration time to be either combinational, or registered on the rising or falling edge of its clock. Each write port stores a whole word on the edge its polarity bit selects, but only while that port's enable is high. All port addresses and data travel on flat buses, with one fixed-width slice per port.

Port addresses are absolute. The array covers the window that starts at a base address and spans the configured word count. Accesses outside that window read as zero and never change the storage. The array can start from a preset image that is held in one flat parameter vector.

Each write port owns a private bank. A small per-word ownership tag records which bank holds the latest value, so no storage element is ever driven from two clocks.

Top module: `mport_ram`

## Requirements
- R1: Read port i takes its address from `rd_addr[i*ADDR_W +: ADDR_W]` and returns data on `rd_data[i*DATA_W +: DATA_W]`. Write port j uses `wr_addr[j*ADDR_W +: ADDR_W]`, `wr_data[j*DATA_W +: DATA_W]` and `wr_en[j*DATA_W +: DATA_W]`. Address A selects word A-BASE.
- R2: When LOAD_INIT is 1, word i holds `INIT_VEC[i*DATA_W +: DATA_W]` before any write. Otherwise every word starts at zero.
- R3: A read port whose RD_SYNC bit is 0 shows the current word at its address combinationally. This includes a word written at the latest write edge.
- R4: A read port whose RD_SYNC bit is 1 captures the word on the rising edge of its clock when its RD_RISE bit is 1, and on the falling edge when that bit is 0. The output holds between capture edges.
- R5: A registered read of a word that is written on the same edge returns the value from before the write.
- R6: Write port j stores its data on the rising edge when WR_RISE bit j is 1, and on the falling edge when it is 0. It writes only when bit 0 of its enable slice is 1. With the enable at 0 the word is unchanged.
- R7: When two write ports with the same polarity write the same word on the same edge, the higher-numbered port's data is kept.
- R8: Addresses below BASE or at or above BASE+DEPTH read as zero, and writes to them change no word.
- R9: While `rst` is high on a registered read port's capture edge, that port's output becomes zero. The stored words are not affected.
- R10: At a write edge, all DATA_W bits of a port's enable slice carry the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous active-high clear of the registered read outputs |
| rd_clk | input | NRD | One clock per read port |
| rd_addr | input | NRD*ADDR_W | Packed read addresses |
| rd_data | output | NRD*DATA_W | Packed read data |
| wr_clk | input | NWR | One clock per write port |
| wr_en | input | NWR*DATA_W | Packed write enables, all bits of a slice equal |
| wr_addr | input | NWR*ADDR_W | Packed write addresses |
| wr_data | input | NWR*DATA_W | Packed write data |

## Verification
Every result is due exactly one clock period after its stimulus. The bench drives all inputs 7 ns after a rising edge and samples 5 ns after the next rising edge. The bench mixes rising-edge and falling-edge ports on one clock, so that sample point falls after the falling-edge write and the falling-edge capture, and after the rising-edge write and the rising-edge capture. The reference array applies those four events in the same order. The falling-edge read port therefore expects the value from before any of this step's writes, and the rising-edge read port expects the value after the falling-edge write only. The combinational port expects the value after all writes. The driver pushes these three expectations when it drives, and the monitor pops and compares them at the next sample point.

// File: rtl/mport_ram_pkg.sv
package mport_ram_pkg;

  // Width of an index able to name n distinct items, never below one bit.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mport_ram_amap.sv
module mport_ram_amap #(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 16,
  parameter int BASE   = 0,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  logic [31:0] abs_a;
  logic [31:0] rel_a;

  always_comb begin
    abs_a = 32'(addr);
    rel_a = abs_a - 32'(BASE);
    hit   = (abs_a >= 32'(BASE)) && (rel_a < 32'(DEPTH));
    idx   = rel_a[IDX_W-1:0];
  end

endmodule

// File: rtl/mport_ram_wbank.sv
module mport_ram_wbank #(
  parameter int                      DEPTH    = 16,
  parameter int                      DATA_W   = 8,
  parameter int                      IDX_W    = 4,
  parameter int                      TAG_W    = 1,
  parameter int                      NLK      = 4,
  parameter bit                      RISE     = 1'b1,
  parameter bit                      LOAD     = 1'b0,
  parameter logic [DEPTH*DATA_W-1:0] INIT_VEC = '0
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [IDX_W-1:0]             widx,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [TAG_W-1:0]             wtag,
  input  logic [NLK-1:0][IDX_W-1:0]    lk_idx,
  output logic [NLK-1:0][DATA_W-1:0]   lk_data,
  output logic [NLK-1:0][TAG_W-1:0]    lk_tag
);

  logic [DATA_W-1:0] words [DEPTH];
  logic [TAG_W-1:0]  tags  [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      words[i] = LOAD ? INIT_VEC[i*DATA_W +: DATA_W] : '0;
      tags[i]  = '0;
    end
  end

  generate
    if (RISE) begin : g_pos
      always_ff @(posedge clk) begin
        if (we) begin
          words[widx] <= wdata;
          tags[widx]  <= wtag;
        end
      end
    end else begin : g_neg
      always_ff @(negedge clk) begin
        if (we) begin
          words[widx] <= wdata;
          tags[widx]  <= wtag;
        end
      end
    end
  endgenerate

  generate
    for (genvar k = 0; k < NLK; k++) begin : g_lk
      assign lk_data[k] = words[lk_idx[k]];
      assign lk_tag[k]  = tags[lk_idx[k]];
    end
  endgenerate

endmodule

// File: rtl/mport_ram_rport.sv
module mport_ram_rport #(
  parameter int DATA_W = 8,
  parameter bit SYNC   = 1'b1,
  parameter bit RISE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] visible;
  assign visible = hit ? word : '0;

  generate
    if (SYNC) begin : g_reg
      logic [DATA_W-1:0] q;
      if (RISE) begin : g_pos
        always_ff @(posedge clk) begin
          if (rst) q <= '0;
          else     q <= visible;
        end
      end else begin : g_neg
        always_ff @(negedge clk) begin
          if (rst) q <= '0;
          else     q <= visible;
        end
      end
      assign dout = q;
    end else begin : g_comb
      logic unused_ctl;
      assign unused_ctl = clk ^ rst;
      assign dout = visible;
    end
  endgenerate

endmodule

// File: rtl/mport_ram.sv
module mport_ram #(
  parameter int                      ADDR_W    = 6,
  parameter int                      DEPTH     = 16,
  parameter int                      DATA_W    = 8,
  parameter int                      BASE      = 0,
  parameter int                      NRD       = 2,
  parameter int                      NWR       = 2,
  parameter logic [NRD-1:0]          RD_SYNC   = '1,
  parameter logic [NRD-1:0]          RD_RISE   = '1,
  parameter logic [NWR-1:0]          WR_RISE   = '1,
  parameter bit                      LOAD_INIT = 1'b0,
  parameter logic [DEPTH*DATA_W-1:0] INIT_VEC  = '0
) (
  input  logic                  rst,
  input  logic [NRD-1:0]        rd_clk,
  input  logic [NRD*ADDR_W-1:0] rd_addr,
  output logic [NRD*DATA_W-1:0] rd_data,
  input  logic [NWR-1:0]        wr_clk,
  input  logic [NWR*DATA_W-1:0] wr_en,
  input  logic [NWR*ADDR_W-1:0] wr_addr,
  input  logic [NWR*DATA_W-1:0] wr_data
);

  localparam int IDX_W = mport_ram_pkg::idx_width(DEPTH);
  localparam int TAG_W = mport_ram_pkg::idx_width(NWR);
  localparam int NLK   = NRD + NWR;   // lookups: read ports first, then write ports

  logic [NLK-1:0][IDX_W-1:0]            lk_idx;
  logic [NLK-1:0]                       lk_hit;
  logic [NWR-1:0][NLK-1:0][DATA_W-1:0]  bk_data;
  logic [NWR-1:0][NLK-1:0][TAG_W-1:0]   bk_tag;
  logic [NLK-1:0][TAG_W-1:0]            owner;
  logic [NWR-1:0]                       want;
  logic [NWR-1:0]                       go;
  logic [NWR-1:0][TAG_W-1:0]            new_tag;
  logic [NRD-1:0][DATA_W-1:0]           rd_word;
  logic                                 unused_en;

  // Only bit 0 of each enable slice steers the write; the rest must match it.
  assign unused_en = ^wr_en;

  // Address window mapping for every lookup.
  generate
    for (genvar k = 0; k < NLK; k++) begin : g_map
      logic [ADDR_W-1:0] a;
      if (k < NRD) begin : g_rd
        assign a = rd_addr[k*ADDR_W +: ADDR_W];
      end else begin : g_wr
        assign a = wr_addr[(k-NRD)*ADDR_W +: ADDR_W];
      end
      mport_ram_amap #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH),
        .BASE   (BASE),
        .IDX_W  (IDX_W)
      ) u_amap (
        .addr (a),
        .hit  (lk_hit[k]),
        .idx  (lk_idx[k])
      );
    end
  endgenerate

  // Owner of each looked-up word: XOR of every bank's tag for that word.
  always_comb begin
    for (int k = 0; k < NLK; k++) begin
      owner[k] = '0;
      for (int p = 0; p < NWR; p++) owner[k] = owner[k] ^ bk_tag[p][k];
    end
  end

  // Write qualification and same-edge collision resolution (higher port wins).
  always_comb begin
    for (int p = 0; p < NWR; p++) want[p] = wr_en[p*DATA_W] && lk_hit[NRD+p];
    for (int p = 0; p < NWR; p++) begin
      go[p] = want[p];
      for (int q = p + 1; q < NWR; q++) begin
        if (want[q] && (WR_RISE[q] == WR_RISE[p]) && (lk_idx[NRD+q] == lk_idx[NRD+p]))
          go[p] = 1'b0;
      end
      // Choose own tag so the XOR over all banks names this port.
      new_tag[p] = TAG_W'(p) ^ owner[NRD+p] ^ bk_tag[p][NRD+p];
    end
  end

  generate
    for (genvar p = 0; p < NWR; p++) begin : g_bank
      mport_ram_wbank #(
        .DEPTH    (DEPTH),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .TAG_W    (TAG_W),
        .NLK      (NLK),
        .RISE     (WR_RISE[p]),
        .LOAD     ((p == 0) && LOAD_INIT),
        .INIT_VEC (INIT_VEC)
      ) u_bank (
        .clk     (wr_clk[p]),
        .we      (go[p]),
        .widx    (lk_idx[NRD+p]),
        .wdata   (wr_data[p*DATA_W +: DATA_W]),
        .wtag    (new_tag[p]),
        .lk_idx  (lk_idx),
        .lk_data (bk_data[p]),
        .lk_tag  (bk_tag[p])
      );
    end
  endgenerate

  always_comb begin
    for (int k = 0; k < NRD; k++) rd_word[k] = bk_data[owner[k]][k];
  end

  generate
    for (genvar k = 0; k < NRD; k++) begin : g_rport
      mport_ram_rport #(
        .DATA_W (DATA_W),
        .SYNC   (RD_SYNC[k]),
        .RISE   (RD_RISE[k])
      ) u_rport (
        .clk  (rd_clk[k]),
        .rst  (rst),
        .hit  (lk_hit[k]),
        .word (rd_word[k]),
        .dout (rd_data[k*DATA_W +: DATA_W])
      );
    end
  endgenerate

endmodule

// File: rtl/mport_ram_chk.sv
module mport_ram_chk #(
  parameter int             ADDR_W  = 6,
  parameter int             DEPTH   = 16,
  parameter int             DATA_W  = 8,
  parameter int             BASE    = 0,
  parameter int             NRD     = 2,
  parameter int             NWR     = 2,
  parameter logic [NRD-1:0] RD_SYNC = '1,
  parameter logic [NRD-1:0] RD_RISE = '1,
  parameter logic [NWR-1:0] WR_RISE = '1
) (
  input logic                  rst,
  input logic [NRD-1:0]        rd_clk,
  input logic [NRD*ADDR_W-1:0] rd_addr,
  input logic [NRD*DATA_W-1:0] rd_data,
  input logic [NWR-1:0]        wr_clk,
  input logic [NWR*DATA_W-1:0] wr_en
);

  function automatic bit outside(input logic [ADDR_W-1:0] a);
    return (32'(a) < 32'(BASE)) || (32'(a) >= 32'(BASE + DEPTH));
  endfunction

  generate
    for (genvar i = 0; i < NRD; i++) begin : g_rd
      wire ck = rd_clk[i] ^ ~RD_RISE[i];
      if (RD_SYNC[i]) begin : g_sync
        // R9
        reset_clear_chk: assert property (@(posedge ck) disable iff (rst)
          $past(rst) |-> (rd_data[i*DATA_W +: DATA_W] == '0));
        // R8
        oob_sync_zero_chk: assert property (@(posedge ck) disable iff (rst)
          outside(rd_addr[i*ADDR_W +: ADDR_W]) |=> (rd_data[i*DATA_W +: DATA_W] == '0));
      end else begin : g_async
        // R8
        oob_async_zero_chk: assert property (@(posedge ck) disable iff (rst)
          outside(rd_addr[i*ADDR_W +: ADDR_W]) |-> (rd_data[i*DATA_W +: DATA_W] == '0));
      end
    end
    for (genvar p = 0; p < NWR; p++) begin : g_wr
      wire wk = wr_clk[p] ^ ~WR_RISE[p];
      // R10
      enable_uniform_chk: assert property (@(posedge wk) disable iff (rst)
        (wr_en[p*DATA_W +: DATA_W] == '0) || (wr_en[p*DATA_W +: DATA_W] == '1));
    end
  endgenerate

endmodule

bind mport_ram mport_ram_chk #(
  .ADDR_W  (ADDR_W),
  .DEPTH   (DEPTH),
  .DATA_W  (DATA_W),
  .BASE    (BASE),
  .NRD     (NRD),
  .NWR     (NWR),
  .RD_SYNC (RD_SYNC),
  .RD_RISE (RD_RISE),
  .WR_RISE (WR_RISE)
) u_chk (
  .rst     (rst),
  .rd_clk  (rd_clk),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .wr_clk  (wr_clk),
  .wr_en   (wr_en)
);

// File: tb/mport_ram_tb.sv
module mport_ram_tb;

  localparam int ADDR_W = 6;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 8;
  localparam int BASE   = 4;
  localparam int NRD    = 3;
  localparam int NWR    = 3;

  function automatic logic [7:0] init_word(input int i);
    return 8'(i * 37 + 11);
  endfunction

  function automatic logic [DEPTH*DATA_W-1:0] make_init();
    logic [DEPTH*DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < DEPTH; i++) v[i*DATA_W +: DATA_W] = init_word(i);
    return v;
  endfunction

  localparam logic [DEPTH*DATA_W-1:0] IMG = make_init();

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [NRD*ADDR_W-1:0] rd_addr = '0;
  logic [NRD*DATA_W-1:0] rd_data;
  logic [NWR*DATA_W-1:0] wr_en;
  logic [NWR*ADDR_W-1:0] wr_addr = '0;
  logic [NWR*DATA_W-1:0] wr_data = '0;
  logic [NWR-1:0]        we_bits = '0;

  always #10 clk = ~clk;

  always_comb begin
    for (int p = 0; p < NWR; p++) wr_en[p*DATA_W +: DATA_W] = {DATA_W{we_bits[p]}};
  end

  // Port 0: registered rising, port 1: registered falling, port 2: combinational.
  // Write ports 0 and 1 rising, write port 2 falling.
  mport_ram #(
    .ADDR_W    (ADDR_W),
    .DEPTH     (DEPTH),
    .DATA_W    (DATA_W),
    .BASE      (BASE),
    .NRD       (NRD),
    .NWR       (NWR),
    .RD_SYNC   (3'b011),
    .RD_RISE   (3'b101),
    .WR_RISE   (3'b011),
    .LOAD_INIT (1'b1),
    .INIT_VEC  (IMG)
  ) u_dut (
    .rst     (rst),
    .rd_clk  ({NRD{clk}}),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_clk  ({NWR{clk}}),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  typedef struct {
    int         port;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t      sb[$];
  logic [7:0] ref_mem [DEPTH];
  int         n_chk  = 0;
  int         n_fail = 0;
  bit         done   = 1'b0;

  function automatic logic [7:0] ref_rd(input logic [5:0] a);
    if (int'(a) >= BASE && int'(a) < BASE + DEPTH) return ref_mem[int'(a) - BASE];
    return 8'h00;
  endfunction

  task automatic ref_wr(input logic [5:0] a, input logic [7:0] d);
    if (int'(a) >= BASE && int'(a) < BASE + DEPTH) ref_mem[int'(a) - BASE] = d;
  endtask

  // Driver: drives one step 7 ns after a rising edge and queues its results.
  task automatic step(input bit rs, input logic [2:0] we,
                      input logic [2:0][5:0] wa, input logic [2:0][7:0] wd,
                      input logic [2:0][5:0] ra, input string tag);
    item_t it;
    logic [7:0] e0, e1, e2;
    @(posedge clk);
    #7;
    rst     = rs;
    we_bits = we;
    for (int p = 0; p < 3; p++) begin
      wr_addr[p*ADDR_W +: ADDR_W] = wa[p];
      wr_data[p*DATA_W +: DATA_W] = wd[p];
      rd_addr[p*ADDR_W +: ADDR_W] = ra[p];
    end
    e1 = ref_rd(ra[1]);                 // falling capture, before any write
    if (we[2]) ref_wr(wa[2], wd[2]);    // falling-edge write
    e0 = ref_rd(ra[0]);                 // rising capture, before rising writes
    if (we[0]) ref_wr(wa[0], wd[0]);
    if (we[1]) ref_wr(wa[1], wd[1]);    // higher port applied last
    e2 = ref_rd(ra[2]);
    if (rs) begin e0 = 8'h00; e1 = 8'h00; end
    it.tag = tag;
    it.port = 0; it.exp = e0; sb.push_back(it);
    it.port = 1; it.exp = e1; sb.push_back(it);
    it.port = 2; it.exp = e2; sb.push_back(it);
  endtask

  // Monitor: 5 ns after each rising edge, compares everything queued.
  initial begin
    item_t it;
    logic [7:0] act;
    forever begin
      @(posedge clk);
      #5;
      while (sb.size() > 0) begin
        it  = sb.pop_front();
        act = rd_data[it.port*DATA_W +: DATA_W];
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s read port %0d actual %h expected %h", it.tag, it.port, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired before the sequence completed");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0][5:0] wa, ra;
    logic [2:0][7:0] wd;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = init_word(i);
    wa = '0; wd = '0;

    // R9: registered outputs cleared while rst is high
    ra = {6'd7, 6'd6, 6'd5};
    step(1'b1, 3'b000, wa, wd, ra, "R9 reset");
    step(1'b1, 3'b000, wa, wd, ra, "R9 reset");

    // R2/R1: preset image, each port on a different word
    for (int i = 0; i < DEPTH; i++) begin
      ra[0] = 6'(BASE + i);
      ra[1] = 6'(BASE + (i + 5) % DEPTH);
      ra[2] = 6'(BASE + (i + 9) % DEPTH);
      step(1'b0, 3'b000, wa, wd, ra, "R2 preset image");
    end

    // R5/R3: rising write while every port reads that word
    wa[0] = 6'd10; wd[0] = 8'hAA; ra = {6'd10, 6'd10, 6'd10};
    step(1'b0, 3'b001, wa, wd, ra, "R5 read-before-write / R3 comb");
    step(1'b0, 3'b000, wa, wd, ra, "R6 rising write");

    // R4/R6: falling-edge write port
    wa[2] = 6'd11; wd[2] = 8'h5C; ra = {6'd11, 6'd11, 6'd11};
    step(1'b0, 3'b100, wa, wd, ra, "R4 R6 falling edge");
    step(1'b0, 3'b000, wa, wd, ra, "R6 falling write");

    // R6: enable low leaves the word alone
    wa[0] = 6'd12; wd[0] = 8'hFF; ra = {6'd12, 6'd12, 6'd12};
    step(1'b0, 3'b000, wa, wd, ra, "R6 enable low");
    step(1'b0, 3'b000, wa, wd, ra, "R6 enable low");

    // R7: same word, same edge, port 1 beats port 0
    wa[0] = 6'd13; wd[0] = 8'h11; wa[1] = 6'd13; wd[1] = 8'h22; ra = {6'd13, 6'd13, 6'd13};
    step(1'b0, 3'b011, wa, wd, ra, "R7 collision");
    step(1'b0, 3'b000, wa, wd, ra, "R7 collision");

    // R8: writes outside the window (20 would alias word 0) and reads there
    wa[0] = 6'd20; wd[0] = 8'hEE; wa[2] = 6'd3; wd[2] = 8'hDD; ra = {6'd4, 6'd3, 6'd20};
    step(1'b0, 3'b101, wa, wd, ra, "R8 out of window");
    ra = {6'd4, 6'd4, 6'd4};
    step(1'b0, 3'b000, wa, wd, ra, "R8 word 0 untouched");

    // R1 R3 R4 R5 R6 R7 R8: mixed traffic against the reference array
    for (int n = 0; n < 400; n++) begin
      for (int p = 0; p < 3; p++) begin
        wa[p] = 6'($urandom_range(0, 23));
        wd[p] = 8'($urandom);
        ra[p] = 6'($urandom_range(0, 23));
      end
      if (n % 4 == 0) wa[1] = wa[0];
      step(1'b0, 3'($urandom), wa, wd, ra, "R1/R3/R4/R5/R6/R7/R8 mixed");
    end

    step(1'b0, 3'b000, wa, wd, ra, "R6 drain");
    @(posedge clk);
    @(posedge clk);
    #6;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule